// File: doc/BRIEF.md
# Streaming CRC-8 Checker for 1-Wire Data

This block keeps a running 8-bit CRC over a stream of bytes, such as a 64-bit ROM code or a scratchpad read. Each byte presented with its valid strobe is folded into the running value in a single clock cycle. The CRC uses the reflected form of the polynomial x^8+x^5+x^4+1. Bits are taken least significant first, and the running value starts at zero.

A caller clears the block at the start of a block of data and streams in the bytes. It then reads the CRC. To check a received block, the caller streams the block together with its trailing CRC byte and looks at the zero flag. The flag is high exactly when the running CRC is zero, so a good block leaves it high.

A parameter selects how one byte is folded in. The first choice is an unrolled network of eight shift-and-conditional-XOR stages. The second is a 256-entry lookup table that is computed at elaboration. Both choices give the same results.

Top module: `ow_crc8_stream`

## Requirements
- R1: While reset is high, and in the cycle after it is released, crc_value is 0x00 and crc_is_zero is 1.
- R2: When byte_valid is 1 and clear is 0 at a rising edge, crc_value after that edge equals the fold of the previous crc_value with byte_in. The fold XORs the byte into the CRC, then runs eight rounds of "shift right by one; if the bit shifted out was 1, XOR with 0x8C".
- R3: When both byte_valid and clear are 0 at a rising edge, crc_value does not change.
- R4: When clear is 1 at a rising edge, crc_value becomes 0x00 after that edge, whatever byte_valid and byte_in are.
- R5: crc_is_zero is 1 in every cycle in which crc_value is 0x00, and 0 otherwise.
- R6: Starting from 0x00, folding a single byte gives these values: 0x00 to 0x00, 0x01 to 0x5E, 0x02 to 0xBC, 0x80 to 0x8C, and 0xFF to 0x35.
- R7: If a block of bytes is followed by its own CRC byte, crc_value ends at 0x00 and crc_is_zero ends at 1.
- R8: The network variant (USE_TABLE=0) and the table variant (USE_TABLE=1) give identical outputs for the same input sequence.
- R9: Bytes can arrive on consecutive cycles in blocks of any length, and each one is folded with no stall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| clear | input | 1 | Restart the running CRC at 0x00; takes priority over byte_valid |
| byte_in | input | DATA_W | Byte to fold in, least significant bit first |
| byte_valid | input | 1 | byte_in is folded at this edge |
| crc_value | output | CRC_W | Current running CRC |
| crc_is_zero | output | 1 | High when crc_value is 0x00 |

## Verification
The clear strobe and a valid byte can land on the same edge. When they do, clear must win and the byte must be discarded. The bench drives this collision on purpose after the CRC has been made non-zero, using a byte that would otherwise give a non-zero result. It also raises clear at random during long random streams. After each collision the bench expects crc_value to read 0x00 and crc_is_zero to read 1. This is judged both by a directed check and by a behavioural model that is compared on every clock.

// File: rtl/ow_crc8_pkg.sv
package ow_crc8_pkg;
   localparam int          OW_CRC_W    = 8;
   localparam logic [7:0]  OW_POLY_REF = 8'h8C;
   localparam logic [7:0]  OW_INIT     = 8'h00;
endpackage

// File: rtl/ow_crc8_fold_net.sv
module ow_crc8_fold_net #(
   parameter int                CRC_W = 8,
   parameter logic [CRC_W-1:0]  POLY  = 8'h8C
) (
   input  logic [CRC_W-1:0] crc_in,
   input  logic [CRC_W-1:0] data_in,
   output logic [CRC_W-1:0] crc_out
);
   localparam int ROUNDS = CRC_W;

   logic [CRC_W-1:0] stage [ROUNDS+1];

   assign stage[0] = crc_in ^ data_in;

   for (genvar i = 0; i < ROUNDS; i++) begin : g_round
      assign stage[i+1] = (stage[i] >> 1) ^ (stage[i][0] ? POLY : '0);
   end

   assign crc_out = stage[ROUNDS];
endmodule

// File: rtl/ow_crc8_fold_rom.sv
module ow_crc8_fold_rom #(
   parameter int                CRC_W = 8,
   parameter logic [CRC_W-1:0]  POLY  = 8'h8C
) (
   input  logic [CRC_W-1:0] crc_in,
   input  logic [CRC_W-1:0] data_in,
   output logic [CRC_W-1:0] crc_out
);
   localparam int ENTRIES = 2 ** CRC_W;

   function automatic logic [CRC_W-1:0] entry_of(input int unsigned idx);
      logic [CRC_W-1:0] v;
      v = CRC_W'(idx);
      for (int b = 0; b < CRC_W; b++)
         v = v[0] ? ((v >> 1) ^ POLY) : (v >> 1);
      return v;
   endfunction

   logic [CRC_W-1:0] rom [ENTRIES];

   for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
      assign rom[e] = entry_of(e);
   end

   assign crc_out = rom[crc_in ^ data_in];
endmodule

// File: rtl/ow_crc8_stream.sv
module ow_crc8_stream
   import ow_crc8_pkg::*;
#(
   parameter int                CRC_W     = OW_CRC_W,
   parameter int                DATA_W    = 8,
   parameter logic [CRC_W-1:0]  POLY      = OW_POLY_REF,
   parameter logic [CRC_W-1:0]  INIT_VAL  = OW_INIT,
   parameter bit                USE_TABLE = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              clear,
   input  logic [DATA_W-1:0] byte_in,
   input  logic              byte_valid,
   output logic [CRC_W-1:0]  crc_value,
   output logic              crc_is_zero
);
   localparam bit INIT_IS_ZERO = (INIT_VAL == '0);

   if (DATA_W != CRC_W) begin : g_bad_width
      $error("ow_crc8_stream: DATA_W must equal CRC_W");
   end
   if (USE_TABLE && CRC_W > 10) begin : g_bad_table
      $error("ow_crc8_stream: table variant limited to CRC_W <= 10");
   end
   if (POLY[CRC_W-1] == 1'b0) begin : g_bad_poly
      $error("ow_crc8_stream: reflected polynomial must have its top bit set");
   end

   logic [CRC_W-1:0] crc_q;
   logic [CRC_W-1:0] fold_out;
   logic [CRC_W-1:0] crc_d;
   logic             zero_q;

   if (USE_TABLE) begin : g_table
      ow_crc8_fold_rom #(.CRC_W(CRC_W), .POLY(POLY)) u_fold (
         .crc_in (crc_q),
         .data_in(byte_in),
         .crc_out(fold_out)
      );
   end else begin : g_net
      ow_crc8_fold_net #(.CRC_W(CRC_W), .POLY(POLY)) u_fold (
         .crc_in (crc_q),
         .data_in(byte_in),
         .crc_out(fold_out)
      );
   end

   always_comb begin
      if (clear)           crc_d = INIT_VAL;
      else if (byte_valid) crc_d = fold_out;
      else                 crc_d = crc_q;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         crc_q  <= INIT_VAL;
         zero_q <= INIT_IS_ZERO;
      end else begin
         crc_q  <= crc_d;
         zero_q <= (crc_d == '0);
      end
   end

   assign crc_value   = crc_q;
   assign crc_is_zero = zero_q;

   AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
      clear |=> (crc_q == INIT_VAL)); // R4

   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
      (!clear && !byte_valid) |=> $stable(crc_q)); // R3

   AST_ZERO_TRACKS: assert property (@(posedge clk) disable iff (rst)
      zero_q == (crc_q == '0)); // R5

   AST_FOLD_NONZERO: assert property (@(posedge clk) disable iff (rst)
      (byte_valid && !clear && (byte_in != crc_q)) |=> (crc_q != '0)); // R2
endmodule

// File: tb/sim_ow_crc8_stream.sv
module sim_ow_crc8_stream;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 100000;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       clear = 1'b0;
   logic [7:0] byte_in = 8'h00;
   logic       byte_valid = 1'b0;
   logic [7:0] crc_a, crc_b;
   logic       zero_a, zero_b;

   int total = 0;
   int bad = 0;
   bit done = 0;
   logic [7:0] expect_crc = 8'h00;

   always #(CLK_PERIOD/2) clk = ~clk;

   ow_crc8_stream #(.USE_TABLE(1'b0)) u0 (
      .clk(clk), .rst(rst), .clear(clear), .byte_in(byte_in),
      .byte_valid(byte_valid), .crc_value(crc_a), .crc_is_zero(zero_a));

   ow_crc8_stream #(.USE_TABLE(1'b1)) u1 (
      .clk(clk), .rst(rst), .clear(clear), .byte_in(byte_in),
      .byte_valid(byte_valid), .crc_value(crc_b), .crc_is_zero(zero_b));

   // bit-serial reference: one data bit at a time, LSB first
   function automatic logic [7:0] ref_fold(input logic [7:0] c, input logic [7:0] d);
      logic [7:0] r = c;
      for (int k = 0; k < 8; k++) begin
         logic fb = r[0] ^ d[k];
         r = {1'b0, r[7:1]};
         if (fb) r = r ^ 8'h8C;
      end
      return r;
   endfunction

   always @(posedge clk) begin
      if (rst || clear)    expect_crc <= 8'h00;
      else if (byte_valid) expect_crc <= ref_fold(expect_crc, byte_in);
   end

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%02h expected=%02h at %0t", req, act, exp, $time);
      end
   endtask

   // per-clock comparison against the model
   always @(negedge clk) begin
      if (!rst && !done) begin
         chk("R2", crc_a, expect_crc);
         chk("R5", {7'd0, zero_a}, {7'd0, expect_crc == 8'h00});
         chk("R8", crc_b, crc_a);
         chk("R8", {7'd0, zero_b}, {7'd0, zero_a});
      end
   end

   task automatic put(input logic c, input logic v, input logic [7:0] d);
      @(negedge clk);
      clear = c; byte_valid = v; byte_in = d;
   endtask

   task automatic single(input logic [7:0] d, input logic [7:0] exp);
      put(1'b1, 1'b0, 8'h00);
      put(1'b0, 1'b1, d);
      put(1'b0, 1'b0, 8'h00);
      @(negedge clk);
      chk("R6", crc_a, exp);
      chk("R6", crc_b, exp);
   endtask

   initial begin : watchdog
      for (int n = 0; n < WATCHDOG && !done; n++) @(posedge clk);
      if (!done) begin
         done = 1;
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : main
      logic [7:0] blk_crc;
      logic [7:0] held;
      repeat (3) @(negedge clk);
      chk("R1", crc_a, 8'h00);
      chk("R1", {7'd0, zero_a}, 8'h01);
      put(1'b0, 1'b0, 8'h00);
      rst = 1'b0;
      @(negedge clk);
      chk("R1", crc_a, 8'h00);
      chk("R1", {7'd0, zero_b}, 8'h01);

      single(8'h00, 8'h00);
      single(8'h01, 8'h5E);
      single(8'h02, 8'hBC);
      single(8'h80, 8'h8C);
      single(8'hFF, 8'h35);

      // R3: idle cycles keep the value
      put(1'b0, 1'b1, 8'hA7);
      put(1'b0, 1'b0, 8'h3C);
      @(negedge clk);
      held = crc_a;
      repeat (4) put(1'b0, 1'b0, 8'($urandom));
      @(negedge clk);
      chk("R3", crc_a, held);

      // R4: clear collides with a valid byte
      put(1'b0, 1'b1, 8'h11);
      put(1'b1, 1'b1, 8'h55);
      put(1'b0, 1'b0, 8'h00);
      @(negedge clk);
      chk("R4", crc_a, 8'h00);
      chk("R4", {7'd0, zero_a}, 8'h01);

      // R7 / R9: back-to-back block plus its own CRC byte
      for (int len = 1; len <= 12; len += 5) begin
         put(1'b1, 1'b0, 8'h00);
         blk_crc = 8'h00;
         for (int i = 0; i < len; i++) begin
            logic [7:0] b = 8'($urandom);
            blk_crc = ref_fold(blk_crc, b);
            put(1'b0, 1'b1, b);
         end
         put(1'b0, 1'b1, blk_crc);
         put(1'b0, 1'b0, 8'h00);
         @(negedge clk);
         chk("R7", crc_a, 8'h00);
         chk("R7", {7'd0, zero_a}, 8'h01);
      end

      // R9 / R2: random streams with occasional clears
      for (int i = 0; i < 2000; i++)
         put(($urandom % 23) == 0, ($urandom % 4) != 0, 8'($urandom));
      put(1'b0, 1'b0, 8'h00);
      repeat (2) @(negedge clk);

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule